// File: doc/BRIEF.md
# Trace Message Queue Overrun Controller

This block stands between three trace message sources (branch, data and ownership) and a transmit queue of fixed depth. Each source raises a request line and holds it until the block acknowledges it. An 8-bit control word sets three things: which trace classes are enabled, what the block does with a message that arrives while the queue is full, and what a falling edge on the external event-in pin means. When the queue has room, the block forwards one enabled message per cycle into the queue. When the queue is full, it either drops the message and queues an overrun marker later, or it holds the CPU stalled for the message classes that the control word selects.

Watchpoint start and stop pulses from outside the block turn data trace and branch trace on and off inside the live control word. The event-in pin is asynchronous. The block synchronizes it, detects falling edges, and turns each edge into a one-cycle trace synchronization pulse or breakpoint pulse, depending on the event code.

Top module: `trace_ovr_ctl`

## Requirements
- R1: After reset the control word reads 0, and `qPush`, `cpuStall`, `syncReq` and `brkReq` are all low.
- R2: The control word is laid out as [7:5] overrun code, [4:3] event code and [2:0] trace enables. Enable bit 0 is ownership, bit 1 is data and bit 2 is branch. A request from a class whose enable bit is 0 is acknowledged in the same cycle and is never pushed. The request and acknowledge buses use bit 0 for ownership, bit 1 for data and bit 2 for branch.
- R3: When the queue is not full and no overrun marker is owed, the block pushes one enabled message per cycle and acknowledges it. Branch has the highest priority, then data, then ownership. `qKind` is 0 for ownership, 1 for data, 2 for branch and 3 for an overrun marker.
- R4: Overrun code 000 means no class stalls. An enabled request that arrives while `qFull` is high is acknowledged and dropped. In the first cycle that the queue is not full, an overrun marker (kind 3) is pushed before any other message, and enabled requests wait during that cycle.
- R5: Overrun code 001 stalls for branch and ownership only. While `qFull` is high and one of those classes is requesting, `cpuStall` is high in the same cycle and that request stays unacknowledged. Data requests are dropped as in R4.
- R6: Overrun code 010 stalls for data and ownership only. Branch requests are dropped as in R4.
- R7: Overrun code 011 stalls for all three classes. No message is dropped and no overrun marker is produced.
- R8: Overrun codes 100 through 111 behave exactly like 000.
- R9: A start pulse on `wpStart[0]` sets data enable bit 1, and a start pulse on `wpStart[1]` sets branch enable bit 2. A stop pulse on the same index clears that bit. If start and stop arrive on the same index together, stop wins. A control write in the same cycle overrides both.
- R10: With event code 00, a falling edge on `evtIn` produces exactly one `syncReq` pulse, provided data or branch trace is enabled. The pulse is visible in the cycle after the second rising clock edge that follows the edge.
- R11: With event code 01, a falling edge produces exactly one `brkReq` pulse, with the same timing as R10, but only while `dbgEnable` is high.
- R12: Event codes 10 and 11 produce no pulse. A rising edge on `evtIn` never produces a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlWe | input | 1 | Write strobe for the control word |
| ctlWdata | input | 8 | Value to write to the control word |
| wpStart | input | 2 | Watchpoint start pulses: bit 0 data, bit 1 branch |
| wpStop | input | 2 | Watchpoint stop pulses: bit 0 data, bit 1 branch |
| evtIn | input | 1 | Asynchronous event-in pin, idle high |
| dbgEnable | input | 1 | Debug mode enabled |
| srcReq | input | 3 | Message requests: bit 0 ownership, bit 1 data, bit 2 branch |
| srcAck | output | 3 | Per-class acknowledge (message consumed) |
| qFull | input | 1 | Transmit queue is full |
| qPush | output | 1 | Push one message into the queue |
| qKind | output | 2 | Kind of the pushed message |
| cpuStall | output | 1 | CPU stall request |
| syncReq | output | 1 | Trace synchronization pulse |
| brkReq | output | 1 | Breakpoint pulse |
| ctlOut | output | 8 | Live control word |

## Verification
The bench sends requests from all three classes together while the queue is full, once for every overrun code. Getting the class-to-code mapping wrong shows up as a stall on a dropped class or an acknowledge on a held class. Reserved codes are checked to make sure they do not stall, and a design that decodes only the low two bits would stall on them. The bench also checks that the overrun marker comes before a waiting branch message, and a design that arbitrates the marker last would push the branch message first. On the event pin it counts pulses per edge and checks the exact cycle they appear in. This catches a missing synchronizer stage, pulses on rising edges, and breakpoints issued with debug disabled.

// File: rtl/trace_ovr_pkg.sv
package trace_ovr_pkg;
  localparam int NUM_CLASS = 3;
  localparam int OVR_W     = 3;
  localparam int EVT_W     = 2;
  localparam int MODE_W    = NUM_CLASS;
  localparam int CTL_W     = OVR_W + EVT_W + MODE_W;
  localparam int KIND_W    = 2;
  localparam int WP_W      = 2;

  typedef enum logic [KIND_W-1:0] {
    KIND_OWN    = 2'd0,
    KIND_DATA   = 2'd1,
    KIND_BRANCH = 2'd2,
    KIND_OVR    = 2'd3
  } msgKind_e;

  typedef enum logic [EVT_W-1:0] {
    EVT_SYNC = 2'd0,
    EVT_BRK  = 2'd1,
    EVT_NOP  = 2'd2,
    EVT_RSV  = 2'd3
  } evtCode_e;

  typedef struct packed {
    logic                 push;
    msgKind_e             kind;
    logic [NUM_CLASS-1:0] ack;
    logic                 stall;
    logic                 setOvr;
    logic                 clrOvr;
  } ctlStrobe_t;
endpackage

// File: rtl/trace_ovr_policy.sv
module trace_ovr_policy
  import trace_ovr_pkg::*;
(
  input  logic [NUM_CLASS-1:0] req,
  input  logic [MODE_W-1:0]    mode,
  input  logic [OVR_W-1:0]     ovrCode,
  input  logic                 qFull,
  input  logic                 ovrPend,
  output ctlStrobe_t           strb
);
  logic [NUM_CLASS-1:0] reqEn;
  logic [NUM_CLASS-1:0] reqDis;
  logic [NUM_CLASS-1:0] stallable;
  logic [NUM_CLASS-1:0] grant;
  logic [NUM_CLASS-1:0] holdMask;
  logic [NUM_CLASS-1:0] dropMask;
  msgKind_e             grantKind;

  assign reqEn  = req & mode;
  assign reqDis = req & ~mode;

  // Per-code set of classes that stall; ownership is part of every stall set.
  always_comb begin
    case (ovrCode)
      3'b001:  stallable = 3'b101;
      3'b010:  stallable = 3'b011;
      3'b011:  stallable = 3'b111;
      default: stallable = 3'b000;
    endcase
  end

  // Fixed priority: the highest index wins.
  always_comb begin
    grant     = '0;
    grantKind = KIND_OWN;
    for (int i = 0; i < NUM_CLASS; i++) begin
      if (reqEn[i]) begin
        grant     = '0;
        grant[i]  = 1'b1;
        grantKind = msgKind_e'(i);
      end
    end
  end

  assign holdMask = reqEn & stallable;
  assign dropMask = reqEn & ~stallable;

  always_comb begin
    strb        = '0;
    strb.kind   = KIND_OWN;
    if (qFull) begin
      strb.stall  = |holdMask;
      strb.ack    = dropMask | reqDis;
      strb.setOvr = |dropMask;
    end else if (ovrPend) begin
      strb.push   = 1'b1;
      strb.kind   = KIND_OVR;
      strb.clrOvr = 1'b1;
      strb.ack    = reqDis;
    end else begin
      strb.push   = |reqEn;
      strb.kind   = grantKind;
      strb.ack    = grant | reqDis;
    end
  end
endmodule

// File: rtl/trace_ovr_dp.sv
module trace_ovr_dp
  import trace_ovr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlWe,
  input  logic [CTL_W-1:0] ctlWdata,
  input  logic [WP_W-1:0]  wpStart,
  input  logic [WP_W-1:0]  wpStop,
  input  logic             evtIn,
  input  logic             dbgEnable,
  input  ctlStrobe_t       strb,
  output logic [CTL_W-1:0] ctlReg,
  output logic             ovrPend,
  output logic             syncReq,
  output logic             brkReq
);
  localparam int CHAIN_W  = SYNC_STAGES + 1;
  localparam int EVT_LO   = MODE_W;
  localparam int OVR_LO   = MODE_W + EVT_W;

  logic [CHAIN_W-1:0] evtChain;
  logic               evtFall;
  evtCode_e           evtCode;
  logic [MODE_W-1:0]  modeNext;

  // Control word with watchpoint-driven enable updates.
  always_comb begin
    modeNext = ctlReg[MODE_W-1:0];
    for (int w = 0; w < WP_W; w++) begin
      if (wpStop[w])       modeNext[w+1] = 1'b0;
      else if (wpStart[w]) modeNext[w+1] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)       ctlReg <= '0;
    else if (ctlWe)  ctlReg <= ctlWdata;
    else             ctlReg <= {ctlReg[CTL_W-1:MODE_W], modeNext};
  end

  // Overrun marker owed to the queue.
  always_ff @(posedge clk) begin
    if (!rstN)             ovrPend <= 1'b0;
    else if (strb.setOvr)  ovrPend <= 1'b1;
    else if (strb.clrOvr)  ovrPend <= 1'b0;
  end

  // Synchronizer plus one history flop; idles high.
  always_ff @(posedge clk) begin
    if (!rstN) evtChain[0] <= 1'b1;
    else       evtChain[0] <= evtIn;
  end

  for (genvar s = 1; s < CHAIN_W; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN) evtChain[s] <= 1'b1;
      else       evtChain[s] <= evtChain[s-1];
    end
  end

  assign evtFall = evtChain[CHAIN_W-1] & ~evtChain[CHAIN_W-2];
  assign evtCode = evtCode_e'(ctlReg[EVT_LO +: EVT_W]);

  assign syncReq = evtFall && (evtCode == EVT_SYNC) &&
                   (ctlReg[KIND_DATA] || ctlReg[KIND_BRANCH]);
  assign brkReq  = evtFall && (evtCode == EVT_BRK) && dbgEnable;

  logic unusedOvr;
  assign unusedOvr = ^ctlReg[OVR_LO +: OVR_W];
endmodule

// File: rtl/trace_ovr_ctl.sv
module trace_ovr_ctl
  import trace_ovr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ctlWe,
  input  logic [CTL_W-1:0]     ctlWdata,
  input  logic [WP_W-1:0]      wpStart,
  input  logic [WP_W-1:0]      wpStop,
  input  logic                 evtIn,
  input  logic                 dbgEnable,
  input  logic [NUM_CLASS-1:0] srcReq,
  output logic [NUM_CLASS-1:0] srcAck,
  input  logic                 qFull,
  output logic                 qPush,
  output logic [KIND_W-1:0]    qKind,
  output logic                 cpuStall,
  output logic                 syncReq,
  output logic                 brkReq,
  output logic [CTL_W-1:0]     ctlOut
);
  ctlStrobe_t       strb;
  logic [CTL_W-1:0] ctlReg;
  logic             ovrPend;

  trace_ovr_policy u_policy (
    .req     (srcReq),
    .mode    (ctlReg[MODE_W-1:0]),
    .ovrCode (ctlReg[CTL_W-1 -: OVR_W]),
    .qFull   (qFull),
    .ovrPend (ovrPend),
    .strb    (strb)
  );

  trace_ovr_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctlWe     (ctlWe),
    .ctlWdata  (ctlWdata),
    .wpStart   (wpStart),
    .wpStop    (wpStop),
    .evtIn     (evtIn),
    .dbgEnable (dbgEnable),
    .strb      (strb),
    .ctlReg    (ctlReg),
    .ovrPend   (ovrPend),
    .syncReq   (syncReq),
    .brkReq    (brkReq)
  );

  assign srcAck   = strb.ack;
  assign qPush    = strb.push;
  assign qKind    = strb.kind;
  assign cpuStall = strb.stall;
  assign ctlOut   = ctlReg;
endmodule

// File: rtl/trace_ovr_chk.sv
module trace_ovr_chk (
  input logic       clk,
  input logic       rstN,
  input logic       ctlWe,
  input logic [1:0] wpStop,
  input logic       dbgEnable,
  input logic [2:0] srcReq,
  input logic [2:0] srcAck,
  input logic       qFull,
  input logic       qPush,
  input logic [1:0] qKind,
  input logic       cpuStall,
  input logic       syncReq,
  input logic       brkReq,
  input logic [7:0] ctlOut
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rstN |=> !qPush && !cpuStall && ctlOut == 8'h00); // R1
  AST_DIS_NO_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    (qPush && qKind != 2'd3) |-> ctlOut[qKind]); // R2
  AST_ACK_HAS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (srcAck & ~srcReq) == 3'b000); // R3
  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rstN)
    qPush |-> !qFull); // R4
  AST_STALL_ON_FULL: assert property (@(posedge clk) disable iff (!rstN)
    cpuStall |-> qFull); // R5
  AST_RSV_NO_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (ctlOut[7] || ctlOut[7:5] == 3'b000) |-> !cpuStall); // R8
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (wpStop[0] && !ctlWe) |=> !ctlOut[1]); // R9
  AST_SYNC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    syncReq |=> !syncReq); // R10
  AST_SYNC_NEEDS_TRACE: assert property (@(posedge clk) disable iff (!rstN)
    syncReq |-> (ctlOut[1] || ctlOut[2])); // R10
  AST_BRK_NEEDS_DBG: assert property (@(posedge clk) disable iff (!rstN)
    brkReq |-> dbgEnable); // R11
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(syncReq && brkReq)); // R12
endmodule

bind trace_ovr_ctl trace_ovr_chk u_chk (.*);

// File: tb/trace_ovr_ctl_tb.sv
module trace_ovr_ctl_tb;
  logic       clk = 1'b0;
  logic       rstN;
  logic       ctlWe;
  logic [7:0] ctlWdata;
  logic [1:0] wpStart, wpStop;
  logic       evtIn, dbgEnable;
  logic [2:0] srcReq, srcAck;
  logic       qFull, qPush, cpuStall, syncReq, brkReq;
  logic [1:0] qKind;
  logic [7:0] ctlOut;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  trace_ovr_ctl u_dut (
    .clk(clk), .rstN(rstN), .ctlWe(ctlWe), .ctlWdata(ctlWdata),
    .wpStart(wpStart), .wpStop(wpStop), .evtIn(evtIn), .dbgEnable(dbgEnable),
    .srcReq(srcReq), .srcAck(srcAck), .qFull(qFull), .qPush(qPush),
    .qKind(qKind), .cpuStall(cpuStall), .syncReq(syncReq), .brkReq(brkReq),
    .ctlOut(ctlOut)
  );

  // {ctl, req, full, expPush, expKind, expAck, expStall, expOvrNext}
  localparam int NV = 13;
  localparam logic [19:0] VEC [NV] = '{
    {8'h07, 3'b111, 1'b0, 1'b1, 2'd2, 3'b100, 1'b0, 1'b0}, // R3 branch first
    {8'h07, 3'b011, 1'b0, 1'b1, 2'd1, 3'b010, 1'b0, 1'b0}, // R3 data next
    {8'h07, 3'b001, 1'b0, 1'b1, 2'd0, 3'b001, 1'b0, 1'b0}, // R3 ownership
    {8'h01, 3'b111, 1'b0, 1'b1, 2'd0, 3'b111, 1'b0, 1'b0}, // R2 disabled acked
    {8'h00, 3'b111, 1'b0, 1'b0, 2'd0, 3'b111, 1'b0, 1'b0}, // R2 all off
    {8'h07, 3'b101, 1'b1, 1'b0, 2'd0, 3'b101, 1'b0, 1'b1}, // R4 drop
    {8'h27, 3'b111, 1'b1, 1'b0, 2'd0, 3'b010, 1'b1, 1'b1}, // R5
    {8'h47, 3'b111, 1'b1, 1'b0, 2'd0, 3'b100, 1'b1, 1'b1}, // R6
    {8'h67, 3'b111, 1'b1, 1'b0, 2'd0, 3'b000, 1'b1, 1'b0}, // R7
    {8'h87, 3'b010, 1'b1, 1'b0, 2'd0, 3'b010, 1'b0, 1'b1}, // R8 code 100
    {8'hE7, 3'b001, 1'b1, 1'b0, 2'd0, 3'b001, 1'b0, 1'b1}, // R8 code 111
    {8'h21, 3'b100, 1'b1, 1'b0, 2'd0, 3'b100, 1'b0, 1'b0}, // R2 disabled while full
    {8'h27, 3'b001, 1'b1, 1'b0, 2'd0, 3'b000, 1'b1, 1'b0}  // R5 ownership held
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic writeCtl(input logic [7:0] v);
    ctlWe = 1'b1; ctlWdata = v;
    tick();
    ctlWe = 1'b0;
  endtask

  task automatic evtEdge(input string tag, input int expSync, input int expBrk);
    int nSync = 0;
    int nBrk = 0;
    int nRise = 0;
    evtIn = 1'b0;
    for (int k = 0; k < 5; k++) begin
      tick(); #1;
      if (k == 1) begin
        check({tag, " syncReq timing"}, syncReq, expSync);
        check({tag, " brkReq timing"}, brkReq, expBrk);
      end
      nSync += syncReq; nBrk += brkReq;
    end
    check({tag, " sync count"}, nSync, expSync);
    check({tag, " brk count"}, nBrk, expBrk);
    evtIn = 1'b1;
    for (int k = 0; k < 5; k++) begin
      tick(); #1;
      nRise += syncReq + brkReq;
    end
    check("R12 rising edge silent", nRise, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; ctlWe = 1'b0; ctlWdata = '0; wpStart = '0; wpStop = '0;
    evtIn = 1'b1; dbgEnable = 1'b0; srcReq = '0; qFull = 1'b0;
    repeat (3) tick();
    #1;
    check("R1 ctlOut", ctlOut, 8'h00);
    check("R1 qPush", qPush, 1'b0);
    check("R1 cpuStall", cpuStall, 1'b0);
    check("R1 pulses", {syncReq, brkReq}, 2'b00);
    rstN = 1'b1;
    tick();

    // Vector table
    for (int i = 0; i < NV; i++) begin
      logic [19:0] v;
      v = VEC[i];
      writeCtl(v[19:12]);
      srcReq = v[11:9]; qFull = v[8];
      #1;
      check($sformatf("vec%0d push", i), qPush, v[7]);
      if (v[7]) check($sformatf("vec%0d kind", i), qKind, v[6:5]);
      check($sformatf("vec%0d ack", i), srcAck, v[4:2]);
      check($sformatf("vec%0d stall", i), cpuStall, v[1]);
      tick();
      srcReq = '0; qFull = 1'b0;
      #1;
      check($sformatf("vec%0d overrun push", i), qPush, v[0]);
      if (v[0]) check($sformatf("vec%0d overrun kind", i), qKind, 2'd3);
      tick();
    end

    // R4 marker ahead of a waiting branch message
    writeCtl(8'h07);
    srcReq = 3'b001; qFull = 1'b1;
    tick();
    srcReq = 3'b100; qFull = 1'b0;
    #1;
    check("R4 marker first push", qPush, 1'b1);
    check("R4 marker kind", qKind, 2'd3);
    check("R4 branch waits", srcAck, 3'b000);
    tick(); #1;
    check("R4 branch after marker", {qPush, qKind, srcAck}, {1'b1, 2'd2, 3'b100});
    srcReq = '0;
    tick();

    // R9 watchpoint updates
    writeCtl(8'h00);
    wpStart = 2'b01; tick(); wpStart = '0; #1;
    check("R9 data start", ctlOut[2:0], 3'b010);
    wpStart = 2'b10; tick(); wpStart = '0; #1;
    check("R9 branch start", ctlOut[2:0], 3'b110);
    wpStart = 2'b01; wpStop = 2'b01; tick(); wpStart = '0; wpStop = '0; #1;
    check("R9 stop wins", ctlOut[2:0], 3'b100);
    ctlWe = 1'b1; ctlWdata = 8'h01; wpStart = 2'b11; tick();
    ctlWe = 1'b0; wpStart = '0; #1;
    check("R9 write wins", ctlOut, 8'h01);

    // R10 synchronization
    writeCtl(8'h02);
    evtEdge("R10 sync with data", 1, 0);
    writeCtl(8'h04);
    evtEdge("R10 sync with branch", 1, 0);
    writeCtl(8'h01);
    evtEdge("R10 no sync ownership only", 0, 0);
    // R11 breakpoint
    writeCtl(8'h08);
    dbgEnable = 1'b0;
    evtEdge("R11 brk debug off", 0, 0);
    dbgEnable = 1'b1;
    evtEdge("R11 brk debug on", 0, 1);
    // R12 no-op and reserved codes
    writeCtl(8'h16);
    evtEdge("R12 code 10", 0, 0);
    writeCtl(8'h1E);
    evtEdge("R12 code 11", 0, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule